// File: doc/BRIEF.md
# Flash Segment Window Decoder

This block keeps one segment register for each chip select of a serial-flash controller. A segment gives the first and the limit address of the window that a chip select occupies in the controller's flash address space. Both fields count 8 MB units. The block translates each incoming bus address into a one-hot chip-select hit and a byte offset inside the matching segment. It also screens every software update of a segment register against the controller's rules.

A software write goes through several checks. A write that tries to move the start of chip select 0 is corrected back to the window base. A segment that lies outside the window is refused. A segment whose start is not a multiple of its size is recorded but kept. A segment that collides with a neighbour is also recorded but kept. The collision search visits one other chip select per clock, and a busy output covers that scan. The window base, the window span, the number of chip selects and the reset table are all parameters.

Top module: `flash_seg_decoder`

## Requirements
- R1: Reading segment register i returns {limit[7:0], first[7:0], 16'h0}. Bits [31:24] hold the limit and bits [23:16] hold the first unit; an address is the unit value times 2^23 and the limit is exclusive. After reset, register i holds entry i of the parameter table. With the defaults these are [0x40,0x48), [0x48,0x4C), [0x4C,0x50), [0x50,0x54) and [0x54,0x58).
- R2: The first unit of chip select 0 is always the window base unit, 0x40 by default. A write to register 0 that carries another first unit is stored with the base in that field, and err_base_forced is set.
- R3: A write whose limit is at or below the window base unit, or whose first unit is above base plus span (0x60 by default), is refused. The register keeps its old value and err_range is set. The chip-select 0 correction of R2 is applied before this test.
- R4: An accepted segment with a nonzero size (limit minus first, modulo 256) whose first unit is not a multiple of that size is stored and sets err_misalign.
- R5: After an accepted write, busy stays high for NUM_CS cycles while the new segment is compared with every other chip select's segment. Any intersection of the two half-open ranges sets err_overlap, and the segment is still stored.
- R6: A write whose 32-bit value equals the register's current read value has no effect: busy does not rise and no flag changes.
- R7: A write presented while busy is high is ignored.
- R8: For a bus address, hit is one-hot on the lowest-numbered chip select whose range contains it, and seg_offset is the address minus that segment's first address.
- R9: An address in no segment gives hit zero, seg_offset zero and miss high.
- R10: The four error flags are sticky and clear only on reset.
- R11: Writes to a select value of NUM_CS or more are ignored, and reads at such a select return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_sel | input | $clog2(NUM_CS) | Register select for writes and reads |
| cfg_wdata | input | 32 | Write value |
| cfg_rdata | output | 32 | Read value of the selected register |
| busy | output | 1 | Overlap scan in progress; writes are ignored |
| bus_addr | input | 32 | Address to decode |
| hit | output | NUM_CS | One-hot chip-select match |
| seg_offset | output | 32 | Offset within the matching segment |
| miss | output | 1 | Address lies in no segment |
| err_base_forced | output | 1 | Sticky: chip select 0 start write corrected |
| err_range | output | 1 | Sticky: segment outside the window refused |
| err_misalign | output | 1 | Sticky: misaligned segment accepted |
| err_overlap | output | 1 | Sticky: overlapping segment accepted |

## Verification
Several properties are checked on every cycle. The hit vector must never have more than one bit set, and a miss must come with a zero offset. The first unit of chip select 0 must never leave the base. A refused write, or a write made while busy, must leave the register file unchanged. No error flag may ever fall. The bench scenarios cover what the per-cycle properties cannot. They sweep the decode over every 8 MB unit of the 32-bit space, with the expected lowest-index winner computed arithmetically. They also check the exact outcome of each corrected, refused, misaligned and overlapping write, the no-effect rewrite, and the restoration of the table on reset.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int UNIT_SHIFT = 23;

  typedef struct packed {
    logic [7:0] upper;  // exclusive limit, 8 MB units
    logic [7:0] lower;  // first unit
  } seg_t;
endpackage

// File: rtl/seg_rule_check.sv
module seg_rule_check
  import seg_pkg::*;
#(
  parameter logic [7:0] WIN_BASE_UNITS = 8'h40,
  parameter logic [7:0] WIN_SPAN_UNITS = 8'h20
) (
  input  logic is_cs0,
  input  seg_t req,
  output seg_t fixed,
  output logic base_forced,
  output logic out_of_range,
  output logic misaligned
);
  localparam logic [8:0] LOW_BOUND  = {1'b0, WIN_BASE_UNITS};
  localparam logic [8:0] HIGH_BOUND = {1'b0, WIN_BASE_UNITS} + {1'b0, WIN_SPAN_UNITS};

  logic [7:0] size_u;
  logic [7:0] size_nz;

  always_comb begin
    fixed       = req;
    base_forced = 1'b0;
    if (is_cs0 && (req.lower != WIN_BASE_UNITS)) begin
      fixed.lower = WIN_BASE_UNITS;
      base_forced = 1'b1;
    end
    out_of_range = ({1'b0, fixed.upper} <= LOW_BOUND) ||
                   ({1'b0, fixed.lower} >  HIGH_BOUND);
    size_u  = fixed.upper - fixed.lower;
    size_nz = (size_u == 8'd0) ? 8'd1 : size_u;
    misaligned = (size_u != 8'd0) && ((fixed.lower % size_nz) != 8'd0);
  end
endmodule

// File: rtl/seg_match.sv
module seg_match
  import seg_pkg::*;
#(
  parameter int NUM_CS = 5
) (
  input  seg_t [NUM_CS-1:0] segs,
  input  logic [31:0]       addr,
  output logic [NUM_CS-1:0] hit,
  output logic [31:0]       offset,
  output logic              miss
);
  logic [NUM_CS-1:0] in_rng;
  logic [31:0]       base_addr [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    logic [31:0] hi_addr;
    assign base_addr[g] = {1'b0, segs[g].lower, 23'd0};
    assign hi_addr      = {1'b0, segs[g].upper, 23'd0};
    assign in_rng[g]    = (addr >= base_addr[g]) && (addr < hi_addr);
  end

  always_comb begin
    hit    = '0;
    offset = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (in_rng[i]) begin
        hit    = '0;
        hit[i] = 1'b1;
        offset = addr - base_addr[i];
      end
    end
    miss = (in_rng == '0);
  end
endmodule

// File: rtl/seg_overlap_scan.sv
module seg_overlap_scan
  import seg_pkg::*;
#(
  parameter int NUM_CS = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [$clog2(NUM_CS)-1:0] start_cs,
  input  seg_t [NUM_CS-1:0]         segs,
  output logic                      busy,
  output logic                      overlap_hit
);
  localparam int W = $clog2(NUM_CS);
  localparam logic [W-1:0] LAST = W'(NUM_CS - 1);

  logic         active_q, active_d;
  logic [W-1:0] idx_q, idx_d;
  logic [W-1:0] cs_q, cs_d;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    cs_d     = cs_q;
    if (start) begin
      active_d = 1'b1;
      idx_d    = '0;
      cs_d     = start_cs;
    end else if (active_q) begin
      if (idx_q == LAST) active_d = 1'b0;
      else               idx_d    = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      cs_q     <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      cs_q     <= cs_d;
    end
  end

  assign busy = active_q;
  assign overlap_hit = active_q && (idx_q != cs_q) &&
                       (segs[cs_q].lower < segs[idx_q].upper) &&
                       (segs[cs_q].upper > segs[idx_q].lower);
endmodule

// File: rtl/flash_seg_decoder.sv
module flash_seg_decoder
  import seg_pkg::*;
#(
  parameter int                   NUM_CS         = 5,
  parameter logic [7:0]           WIN_BASE_UNITS = 8'h40,
  parameter logic [7:0]           WIN_SPAN_UNITS = 8'h20,
  parameter logic [NUM_CS*8-1:0]  DEF_LOWER      = 40'h54_50_4C_48_40,
  parameter logic [NUM_CS*8-1:0]  DEF_UPPER      = 40'h58_54_50_4C_48
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_CS)-1:0] cfg_sel,
  input  logic [31:0]               cfg_wdata,
  output logic [31:0]               cfg_rdata,
  output logic                      busy,
  input  logic [31:0]               bus_addr,
  output logic [NUM_CS-1:0]         hit,
  output logic [31:0]               seg_offset,
  output logic                      miss,
  output logic                      err_base_forced,
  output logic                      err_range,
  output logic                      err_misalign,
  output logic                      err_overlap
);
  localparam int SELW = $clog2(NUM_CS);

  seg_t [NUM_CS-1:0] seg_q, seg_d;
  seg_t              cur_seg, req_seg, fixed_seg;
  logic              sel_valid, same_val, wr_act, accept;
  logic              f_base, f_range, f_mis, ovl_hit;
  logic [3:0]        flag_q, flag_d;

  // Current contents of the selected register
  always_comb begin
    cur_seg   = '0;
    sel_valid = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (cfg_sel == SELW'(i)) begin
        cur_seg   = seg_q[i];
        sel_valid = 1'b1;
      end
    end
  end

  assign cfg_rdata = {cur_seg.upper, cur_seg.lower, 16'h0000};
  assign req_seg   = cfg_wdata[31:16];
  assign same_val  = (cfg_wdata == cfg_rdata);
  assign wr_act    = cfg_we && !busy && sel_valid && !same_val;

  seg_rule_check #(
    .WIN_BASE_UNITS(WIN_BASE_UNITS),
    .WIN_SPAN_UNITS(WIN_SPAN_UNITS)
  ) u_rule (
    .is_cs0      (cfg_sel == '0),
    .req         (req_seg),
    .fixed       (fixed_seg),
    .base_forced (f_base),
    .out_of_range(f_range),
    .misaligned  (f_mis)
  );

  assign accept = wr_act && !f_range;

  // Next state of the register file and flags
  always_comb begin
    seg_d = seg_q;
    if (accept) begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (cfg_sel == SELW'(i)) seg_d[i] = fixed_seg;
      end
    end
    flag_d    = flag_q;
    flag_d[0] = flag_q[0] | (wr_act && f_base);
    flag_d[1] = flag_q[1] | (wr_act && f_range);
    flag_d[2] = flag_q[2] | (accept && f_mis);
    flag_d[3] = flag_q[3] | ovl_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) begin
        seg_q[i] <= {DEF_UPPER[i*8 +: 8], DEF_LOWER[i*8 +: 8]};
      end
      flag_q <= '0;
    end else begin
      seg_q  <= seg_d;
      flag_q <= flag_d;
    end
  end

  seg_overlap_scan #(.NUM_CS(NUM_CS)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_cs   (cfg_sel),
    .segs       (seg_q),
    .busy       (busy),
    .overlap_hit(ovl_hit)
  );

  seg_match #(.NUM_CS(NUM_CS)) u_match (
    .segs  (seg_q),
    .addr  (bus_addr),
    .hit   (hit),
    .offset(seg_offset),
    .miss  (miss)
  );

  assign err_base_forced = flag_q[0];
  assign err_range       = flag_q[1];
  assign err_misalign    = flag_q[2];
  assign err_overlap     = flag_q[3];
endmodule

// File: rtl/seg_decoder_checks.sv
module seg_decoder_checks
  import seg_pkg::*;
#(
  parameter int         NUM_CS         = 5,
  parameter logic [7:0] WIN_BASE_UNITS = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              busy,
  input logic [NUM_CS-1:0] hit,
  input logic [31:0]       seg_offset,
  input logic              miss,
  input logic              err_base_forced,
  input logic              err_range,
  input logic              err_misalign,
  input logic              err_overlap,
  input seg_t [NUM_CS-1:0] segs
);
  a_r8_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (hit == '0 && seg_offset == 32'd0));

  a_r2_cs0_base: assert property (@(posedge clk) disable iff (!rst_n)
    segs[0].lower == WIN_BASE_UNITS);

  a_r7_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we) |=> $stable(segs));

  a_r3_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_range) |-> $stable(segs));

  a_r10_sticky_base: assert property (@(posedge clk) disable iff (!rst_n)
    err_base_forced |=> err_base_forced);
  a_r10_sticky_range: assert property (@(posedge clk) disable iff (!rst_n)
    err_range |=> err_range);
  a_r10_sticky_mis: assert property (@(posedge clk) disable iff (!rst_n)
    err_misalign |=> err_misalign);
  a_r10_sticky_ovl: assert property (@(posedge clk) disable iff (!rst_n)
    err_overlap |=> err_overlap);
endmodule

bind flash_seg_decoder seg_decoder_checks #(
  .NUM_CS        (NUM_CS),
  .WIN_BASE_UNITS(WIN_BASE_UNITS)
) u_checks (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_we         (cfg_we),
  .busy           (busy),
  .hit            (hit),
  .seg_offset     (seg_offset),
  .miss           (miss),
  .err_base_forced(err_base_forced),
  .err_range      (err_range),
  .err_misalign   (err_misalign),
  .err_overlap    (err_overlap),
  .segs           (seg_q)
);

// File: tb/tb_flash_seg_decoder.sv
module tb_flash_seg_decoder;
  localparam int NCS = 5;

  logic        clk, rst_n, cfg_we, busy, miss;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata, bus_addr, seg_offset;
  logic [4:0]  hit;
  logic        err_base_forced, err_range, err_misalign, err_overlap;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_lo [NCS];
  int m_hi [NCS];
  bit e_base, e_rng, e_mis, e_ovl;

  flash_seg_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
    .bus_addr(bus_addr), .hit(hit), .seg_offset(seg_offset), .miss(miss),
    .err_base_forced(err_base_forced), .err_range(err_range),
    .err_misalign(err_misalign), .err_overlap(err_overlap)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lo = '{64, 72, 76, 80, 84};
    m_hi = '{72, 76, 80, 84, 88};
    e_base = 0; e_rng = 0; e_mis = 0; e_ovl = 0;
  endtask

  task automatic model_write(input int sel, input int lo, input int hi);
    int sz;
    if (sel >= NCS) return;
    if (lo == m_lo[sel] && hi == m_hi[sel]) return;
    if (sel == 0 && lo != 64) begin lo = 64; e_base = 1; end
    if (hi <= 64 || lo > 96) begin e_rng = 1; return; end
    sz = (hi - lo) & 255;
    if (sz != 0 && (lo % sz) != 0) e_mis = 1;
    m_lo[sel] = lo; m_hi[sel] = hi;
    for (int j = 0; j < NCS; j++)
      if (j != sel && lo < m_hi[j] && hi > m_lo[j]) e_ovl = 1;
  endtask

  task automatic drive_write(input int sel, input int lo, input int hi);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel);
    cfg_wdata = {8'(hi), 8'(lo), 16'h0};
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NCS; i++) begin
      cfg_sel = 3'(i); #1;
      chk(cfg_rdata == {8'(m_hi[i]), 8'(m_lo[i]), 16'h0}, req, "readback",
          cfg_rdata, {8'(m_hi[i]), 8'(m_lo[i]), 16'h0});
    end
  endtask

  task automatic check_flags(input string req);
    #1;
    chk({err_base_forced, err_range, err_misalign, err_overlap} ==
        {e_base, e_rng, e_mis, e_ovl}, req, "flags",
        {28'd0, err_base_forced, err_range, err_misalign, err_overlap},
        {28'd0, e_base, e_rng, e_mis, e_ovl});
  endtask

  // R8 and R9: sweep every 8 MB unit at two offsets
  task automatic sweep(input string req);
    logic [31:0] a, exp_off;
    logic [4:0]  exp_hit;
    for (int u = 0; u < 512; u++) begin
      for (int k = 0; k < 2; k++) begin
        a = (32'(u) << 23) | (k == 0 ? 32'd0 : ((32'(u) * 32'h2D5A3) & 32'h7FFFFF));
        exp_hit = '0; exp_off = '0;
        for (int c = NCS - 1; c >= 0; c--) begin
          if (a >= (32'(m_lo[c]) << 23) && a < (32'(m_hi[c]) << 23)) begin
            exp_hit = '0; exp_hit[c] = 1'b1;
            exp_off = a - (32'(m_lo[c]) << 23);
          end
        end
        bus_addr = a; #1;
        chk(hit == exp_hit && seg_offset == exp_off && miss == (exp_hit == 0),
            req, $sformatf("decode %h hit/off", a), {hit, seg_offset[26:0]},
            {exp_hit, exp_off[26:0]});
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; bus_addr = 0; rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset table
    check_regs("R1");
    check_flags("R1");
    chk(busy == 0, "R1", "busy after reset", 32'(busy), 0);
    sweep("R8/R9 default");

    // R6 same-value write
    drive_write(2, 76, 80);
    chk(busy == 0, "R6", "busy on same value", 32'(busy), 0);
    check_flags("R6"); check_regs("R6");

    // R2 chip select 0 start forced
    drive_write(0, 0, 72); model_write(0, 0, 72);
    wait_idle(); check_flags("R2"); check_regs("R2");

    // R3 refused: start beyond window, then end at base
    drive_write(1, 112, 116); model_write(1, 112, 116);
    chk(busy == 0, "R3", "no scan on refusal", 32'(busy), 0);
    check_flags("R3"); check_regs("R3");
    drive_write(1, 60, 64); model_write(1, 60, 64);
    check_flags("R3"); check_regs("R3");

    // R4 misaligned but accepted
    drive_write(4, 90, 94); model_write(4, 90, 94);
    wait_idle(); check_flags("R4"); check_regs("R4");

    // R5 overlap and R7 write while busy
    drive_write(3, 76, 80); model_write(3, 76, 80);
    chk(busy == 1, "R5", "busy after accept", 32'(busy), 1);
    cfg_we = 1; cfg_sel = 1; cfg_wdata = {8'd90, 8'd88, 16'h0};
    @(negedge clk); cfg_we = 0;
    for (int n = 0; n < NCS - 2; n++) @(negedge clk);
    chk(busy == 1, "R5", "busy still in scan", 32'(busy), 1);
    @(negedge clk);
    chk(busy == 0, "R5", "busy ends after NUM_CS cycles", 32'(busy), 0);
    check_flags("R5"); check_regs("R7");
    sweep("R8 after remap");

    // R11 out-of-range select
    for (int s = 5; s < 8; s++) begin
      cfg_sel = 3'(s); #1;
      chk(cfg_rdata == 0, "R11", "read beyond NUM_CS", cfg_rdata, 0);
    end
    drive_write(6, 88, 90);
    chk(busy == 0, "R11", "write beyond NUM_CS", 32'(busy), 0);
    check_regs("R11");

    // R10 flags stay set after a clean write, clear on reset
    drive_write(1, 72, 74); model_write(1, 72, 74);
    wait_idle(); check_flags("R10"); check_regs("R10");
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    model_reset(); @(negedge clk);
    check_flags("R10 reset"); check_regs("R1 reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule